// File: doc/BRIEF.md
# Multi-Channel Frequency Offset Monitor

This block watches up to fourteen input clocks against one shared reference and estimates how far each input's frequency lies from nominal. All clocks arrive as single-cycle tick strobes in the system clock domain. A configuration bit chooses which of two reference tick streams paces the measurement: the master clock or the DPLL output. The reference stream opens and closes a gate made of a fixed number of reference ticks. Over each gate every channel counts its own input ticks and subtracts a nominal count. The signed result is that channel's offset in ppm-scaled units.

At the end of every gate each channel also refreshes a hard alarm. The alarm is set when the size of the offset exceeds a threshold. The threshold is the 4-bit threshold code plus one, times a shared 4-bit monitor factor. A global enable can suppress all alarms. A channel under alarm is reported as unqualified for clock selection.

Software reads one channel at a time. It puts a 4-bit channel number on the select input and reads back an 8-bit signed value. That value times the monitor factor gives the offset.

Top module: `freq_offset_monitor`

## Requirements
- R1: During a gate, each channel counts its input ticks. A gate is the span from the cycle after the previous gate end up to and including the cycle of the GATE_REFS-th selected reference tick. At the gate end the channel stores (count - NOM_CNT) as its signed offset.
- R2: While `alarm_en` is 0, every `hard_alarm` bit reads 0 from the next cycle on, and no alarm is raised at a gate end.
- R3: At a gate end with `alarm_en` = 1, a channel's alarm becomes 1 if |offset| > (`thr_code` + 1) x factor, and otherwise 0. An offset exactly equal to the threshold gives 0.
- R4: While `alarm_en` is 1, `hard_alarm` changes only in the cycle after a gate end. Changing the factor, the threshold or the readout select between gates does not change it.
- R5: `qualified[i]` is 1 exactly when `hard_alarm[i]` is 0.
- R6: `ref_sel` = 0 times the gate with `mstr_tick`; `ref_sel` = 1 times it with `dpll_tick`. The unselected stream has no effect.
- R7: `rd_sel` values 1 to 14 select channel `rd_sel`-1, i.e. bit `rd_sel`-1 of `in_tick`. Values 0 and 15 read back 0.
- R8: `rd_val` is the selected offset divided by the factor, truncated toward zero, as 8-bit two's complement. It is combinational from the stored offset.
- R9: A quotient above +127 reads as 127 (0x7F), and one below -128 reads as -128 (0x80).
- R10: The factor is `fac_code`, except that code 0 acts as factor 1. This applies to both the threshold and the readout.
- R11: After reset, every stored offset is 0, no alarm is set, and every channel is qualified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_tick | input | 14 | One tick strobe per monitored input; bit i is channel i+1 |
| mstr_tick | input | 1 | Master clock reference tick |
| dpll_tick | input | 1 | DPLL output reference tick |
| ref_sel | input | 1 | Reference choice: 0 master, 1 DPLL |
| alarm_en | input | 1 | Global hard alarm enable |
| thr_code | input | 4 | Threshold code; threshold = (code+1) x factor |
| fac_code | input | 4 | Monitor factor (0 behaves as 1) |
| rd_sel | input | 4 | Readout channel number |
| rd_val | output | 8 | Signed scaled offset of the selected channel |
| hard_alarm | output | 14 | Per-channel hard alarm status |
| qualified | output | 14 | Per-channel qualification for clock selection |

## Verification
The assertions assume that tick strobes are single-cycle pulses sampled on the system clock. They also assume that `ref_sel` changes only while the gate counter sits at zero, so a gate is never timed by a mix of the two streams. The stimulus keeps within this by building each gate as a fixed frame of 320 cycles. In each frame the selected stream ticks every tenth cycle and ends on the frame's last cycle, while the unselected stream ticks every third cycle. `ref_sel` and the other configuration inputs change only at frame starts or in idle cycles with no ticks, where nothing is being counted.

// File: rtl/fom_pkg.sv
package fom_pkg;
  localparam int CODE_W = 4;
  localparam int RD_W   = 8;

  // factor code 0 is treated as a factor of one
  function automatic logic [CODE_W-1:0] eff_factor(input logic [CODE_W-1:0] code);
    return (code == '0) ? CODE_W'(1) : code;
  endfunction
endpackage

// File: rtl/fom_gate_timer.sv
module fom_gate_timer #(
  parameter int GATE_REFS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mstr_tick,
  input  logic dpll_tick,
  input  logic ref_sel,
  output logic gate_end
);
  localparam int GW = (GATE_REFS > 2) ? $clog2(GATE_REFS) : 1;
  localparam logic [GW-1:0] LAST = GW'(GATE_REFS - 1);

  logic [GW-1:0] gcnt_q, gcnt_d;
  logic          ref_tick;
  logic          at_last;

  always_comb begin
    ref_tick = ref_sel ? dpll_tick : mstr_tick;
    at_last  = (gcnt_q == LAST);
    gate_end = ref_tick && at_last;
    gcnt_d   = gcnt_q;
    if (ref_tick) begin
      gcnt_d = at_last ? '0 : gcnt_q + GW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gcnt_q <= '0;
    else        gcnt_q <= gcnt_d;
  end
endmodule

// File: rtl/fom_chan.sv
module fom_chan #(
  parameter int CNT_W   = 9,
  parameter int NOM_CNT = 160,
  parameter int THR_W   = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    gate_end,
  input  logic                    alarm_en,
  input  logic [THR_W-1:0]        thr,
  output logic signed [CNT_W:0]   diff,
  output logic                    alarm
);
  localparam int DIFF_W = CNT_W + 1;
  localparam logic [CNT_W-1:0]  CMAX = {CNT_W{1'b1}};
  localparam logic [DIFF_W-1:0] NOM  = DIFF_W'(NOM_CNT);

  logic [CNT_W-1:0]         cnt_q, cnt_d, cnt_fin;
  logic signed [DIFF_W-1:0] diff_q, diff_d, diff_new;
  logic [DIFF_W-1:0]        mag;
  logic                     over;
  logic                     alarm_q, alarm_d;

  always_comb begin
    cnt_fin  = (tick && (cnt_q != CMAX)) ? cnt_q + CNT_W'(1) : cnt_q;
    cnt_d    = gate_end ? '0 : cnt_fin;
    diff_new = $signed({1'b0, cnt_fin}) - $signed(NOM);
    mag      = diff_new[DIFF_W-1] ? (~diff_new + DIFF_W'(1)) : diff_new;
    over     = (mag > DIFF_W'(thr));
    diff_d   = gate_end ? diff_new : diff_q;
    if (!alarm_en)     alarm_d = 1'b0;
    else if (gate_end) alarm_d = over;
    else               alarm_d = alarm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      diff_q  <= '0;
      alarm_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      diff_q  <= diff_d;
      alarm_q <= alarm_d;
    end
  end

  assign diff  = diff_q;
  assign alarm = alarm_q;
endmodule

// File: rtl/fom_readout.sv
module fom_readout
  import fom_pkg::*;
#(
  parameter int NCH    = 14,
  parameter int DIFF_W = 10
) (
  input  logic [NCH-1:0][DIFF_W-1:0] diffs,
  input  logic [3:0]                 rd_sel,
  input  logic [CODE_W-1:0]          fac,
  output logic [RD_W-1:0]            rd_val
);
  localparam logic signed [DIFF_W-1:0] SMAX = DIFF_W'(127);
  localparam logic signed [DIFF_W-1:0] SMIN = -$signed(DIFF_W'(128));

  logic signed [DIFF_W-1:0] sel_diff, fac_s, quot;
  logic                     hit;

  always_comb begin
    sel_diff = '0;
    hit      = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (rd_sel == 4'(i + 1)) begin
        sel_diff = diffs[i];
        hit      = 1'b1;
      end
    end
    fac_s = $signed({{(DIFF_W-CODE_W){1'b0}}, fac});
    quot  = sel_diff / fac_s;
    if (!hit)             rd_val = '0;
    else if (quot > SMAX) rd_val = 8'h7F;
    else if (quot < SMIN) rd_val = 8'h80;
    else                  rd_val = quot[RD_W-1:0];
  end
endmodule

// File: rtl/freq_offset_monitor.sv
module freq_offset_monitor
  import fom_pkg::*;
#(
  parameter int NCH       = 14,
  parameter int GATE_REFS = 32,
  parameter int NOM_CNT   = 160,
  parameter int CNT_W     = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    in_tick,
  input  logic              mstr_tick,
  input  logic              dpll_tick,
  input  logic              ref_sel,
  input  logic              alarm_en,
  input  logic [3:0]        thr_code,
  input  logic [3:0]        fac_code,
  input  logic [3:0]        rd_sel,
  output logic [7:0]        rd_val,
  output logic [NCH-1:0]    hard_alarm,
  output logic [NCH-1:0]    qualified
);
  localparam int DIFF_W = CNT_W + 1;
  localparam int THR_W  = 2 * CODE_W + 1;

  logic [1:0]                 rst_sync;
  logic                       rst_i_n;
  logic                       gate_end;
  logic [CODE_W-1:0]          fac_eff;
  logic [THR_W-1:0]           thr;
  logic [NCH-1:0][DIFF_W-1:0] diffs;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  always_comb begin
    fac_eff = eff_factor(fac_code);
    thr     = (THR_W'(thr_code) + THR_W'(1)) * THR_W'(fac_eff);
  end

  fom_gate_timer #(.GATE_REFS(GATE_REFS)) u_gate (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .mstr_tick (mstr_tick),
    .dpll_tick (dpll_tick),
    .ref_sel   (ref_sel),
    .gate_end  (gate_end)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    fom_chan #(.CNT_W(CNT_W), .NOM_CNT(NOM_CNT), .THR_W(THR_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_i_n),
      .tick     (in_tick[g]),
      .gate_end (gate_end),
      .alarm_en (alarm_en),
      .thr      (thr),
      .diff     (diffs[g]),
      .alarm    (hard_alarm[g])
    );
  end

  fom_readout #(.NCH(NCH), .DIFF_W(DIFF_W)) u_rd (
    .diffs  (diffs),
    .rd_sel (rd_sel),
    .fac    (fac_eff),
    .rd_val (rd_val)
  );

  assign qualified = ~hard_alarm;
endmodule

// File: rtl/fom_checker.sv
module fom_checker #(
  parameter int NCH = 14
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mstr_tick,
  input logic           dpll_tick,
  input logic           ref_sel,
  input logic           alarm_en,
  input logic [3:0]     rd_sel,
  input logic [7:0]     rd_val,
  input logic [NCH-1:0] hard_alarm,
  input logic           gate_end
);
  assert_suppress_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_en |=> (hard_alarm == '0));

  assert_hold_between_gates_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_en && !gate_end) |=> $stable(hard_alarm));

  assert_raise_at_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((hard_alarm & ~$past(hard_alarm)) != '0) |-> ($past(gate_end) && $past(alarm_en)));

  assert_gate_on_selected_ref_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gate_end |-> (ref_sel ? dpll_tick : mstr_tick));

  assert_empty_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_sel == 4'd0) || (32'(rd_sel) > NCH)) |-> (rd_val == 8'h00));
endmodule

bind freq_offset_monitor fom_checker #(.NCH(NCH)) u_fom_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mstr_tick  (mstr_tick),
  .dpll_tick  (dpll_tick),
  .ref_sel    (ref_sel),
  .alarm_en   (alarm_en),
  .rd_sel     (rd_sel),
  .rd_val     (rd_val),
  .hard_alarm (hard_alarm),
  .gate_end   (gate_end)
);

// File: tb/tb_freq_offset_monitor.sv
module tb_freq_offset_monitor;
  localparam int NCH      = 14;
  localparam int GREFS    = 32;
  localparam int NOM      = 160;
  localparam int REFDIV   = 10;
  localparam int GATE_CYC = GREFS * REFDIV;
  localparam int NBLK     = 12;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NCH-1:0]  in_tick;
  logic            mstr_tick, dpll_tick, ref_sel, alarm_en;
  logic [3:0]      thr_code, fac_code, rd_sel;
  logic [7:0]      rd_val;
  logic [NCH-1:0]  hard_alarm, qualified;

  int errors = 0;
  int checks = 0;
  int exp_diff [NCH];
  logic [NCH-1:0] exp_alarm;

  always #4 clk = ~clk;

  freq_offset_monitor #(.NCH(NCH), .GATE_REFS(GREFS), .NOM_CNT(NOM), .CNT_W(9)) dut (
    .clk(clk), .rst_n(rst_n), .in_tick(in_tick), .mstr_tick(mstr_tick),
    .dpll_tick(dpll_tick), .ref_sel(ref_sel), .alarm_en(alarm_en),
    .thr_code(thr_code), .fac_code(fac_code), .rd_sel(rd_sel),
    .rd_val(rd_val), .hard_alarm(hard_alarm), .qualified(qualified)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int efac(input int f);
    return (f == 0) ? 1 : f;
  endfunction

  function automatic int rd_exp(input int ch, input int f);
    int q;
    if (ch < 1 || ch > NCH) return 0;
    q = exp_diff[ch-1] / efac(f);
    if (q > 127)  q = 127;
    if (q < -128) q = -128;
    return q;
  endfunction

  function automatic int blk_thr(input int b);
    return (b == 6) ? 3 : (b * 5) % 16;
  endfunction
  function automatic int blk_fac(input int b);
    return (b == 6) ? 5 : (b * 7) % 16;
  endfunction

  function automatic int kval(input int b, input int c);
    int off;
    case (b)
      0: return NOM;
      2: return GATE_CYC;
      3: return 0;
      6: begin
        off = 19 + (c % 3);
        return (c % 2 == 1) ? NOM - off : NOM + off;
      end
      default: return (b * 53 + c * 29 + 7) % (GATE_CYC + 1);
    endcase
  endfunction

  task automatic check_alarms(input string tag);
    for (int c = 0; c < NCH; c++) begin
      chk({tag, " alarm"}, int'(hard_alarm[c]), int'(exp_alarm[c]));
      chk("R5 qualified", int'(qualified[c]), int'(!exp_alarm[c]));
    end
  endtask

  task automatic sweep_readout(input int fac_keep);
    for (int f = 0; f < 16; f++) begin
      for (int s = 0; s < 16; s++) begin
        @(negedge clk);
        fac_code = 4'(f);
        rd_sel   = 4'(s);
        #1;
        if (s == 0 || s > NCH)
          chk("R7 empty select", int'($signed(rd_val)), 0);
        else if (f == 0)
          chk("R10 factor zero", int'($signed(rd_val)), rd_exp(s, f));
        else
          chk("R8/R9 readout", int'($signed(rd_val)), rd_exp(s, f));
      end
    end
    @(negedge clk);
    fac_code = 4'(fac_keep);
  endtask

  task automatic run_block(input int b);
    int k [NCH];
    int en, sel, thr, fac, mag;
    en  = (b != 4) ? 1 : 0;
    sel = b % 2;
    thr = blk_thr(b);
    fac = blk_fac(b);
    for (int c = 0; c < NCH; c++) k[c] = kval(b, c);
    for (int cyc = 0; cyc < GATE_CYC; cyc++) begin
      @(negedge clk);
      if (cyc == 0) begin
        alarm_en = en[0];
        ref_sel  = sel[0];
        thr_code = 4'(thr);
        fac_code = 4'(fac);
      end
      for (int c = 0; c < NCH; c++) in_tick[c] = (cyc < k[c]);
      // selected stream ends the gate on the last cycle; the other ticks every third cycle
      if (sel == 0) begin
        mstr_tick = (cyc % REFDIV == REFDIV - 1);
        dpll_tick = (cyc % 3 == 2);
      end else begin
        dpll_tick = (cyc % REFDIV == REFDIV - 1);
        mstr_tick = (cyc % 3 == 2);
      end
    end
    @(negedge clk);
    in_tick = '0; mstr_tick = 1'b0; dpll_tick = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      exp_diff[c] = k[c] - NOM;
      mag = (exp_diff[c] < 0) ? -exp_diff[c] : exp_diff[c];
      exp_alarm[c] = (en == 1) && (mag > (thr + 1) * efac(fac));
    end
    #1;
    if (b == 4)      check_alarms("R2 disabled gate");
    else if (b == 6) check_alarms("R3 threshold boundary");
    else if (sel)    check_alarms("R6/R3 dpll reference");
    else             check_alarms("R1/R3 master reference");
    sweep_readout(fac);
    @(negedge clk);
    rd_sel = 4'd1;
    thr_code = 4'(15 - thr);
    #1;
    check_alarms("R4 no change between gates");
    @(negedge clk);
    thr_code = 4'(thr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_tick = '0; mstr_tick = 1'b0; dpll_tick = 1'b0;
    ref_sel = 1'b0; alarm_en = 1'b1; thr_code = 4'd0; fac_code = 4'd1; rd_sel = 4'd0;
    for (int c = 0; c < NCH; c++) exp_diff[c] = 0;
    exp_alarm = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R11: reset state
    for (int s = 0; s < 16; s++) begin
      @(negedge clk);
      rd_sel = 4'(s);
      #1;
      chk("R11 reset readout", int'($signed(rd_val)), 0);
    end
    chk("R11 reset alarms", int'(hard_alarm), 0);
    chk("R11 reset qualified", int'(qualified), (1 << NCH) - 1);

    for (int b = 0; b < NBLK; b++) begin
      run_block(b);
      if (b == 2) begin
        // all channels should be in alarm here; dropping the enable clears them
        chk("R3 large offset alarms", int'(hard_alarm), (1 << NCH) - 1);
        @(negedge clk);
        alarm_en = 1'b0;
        @(negedge clk);
        #1;
        exp_alarm = '0;
        check_alarms("R2 enable dropped");
        @(negedge clk);
        alarm_en = 1'b1;
        @(negedge clk);
        #1;
        check_alarms("R4 re-enable waits for gate");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule